// File: doc/BRIEF.md
# Two-Queue Triggered Command Scheduler

This block sequences conversion command slots for one shared conversion engine on behalf of two independent queues. Each queue owns a contiguous window of a 16-slot command memory. Queue 1 covers a programmable first-to-last window. Queue 2 starts at the slot after queue 1's last slot and ends at its own programmable last slot. A rising edge on a queue's trigger input starts that queue at its first slot. The queue then hands out slot indices one at a time to the converter, waiting for an acknowledge after each one, until it has issued its last slot.

Queue 1 always wins arbitration. When queue 1 starts while queue 2 is part way through its window, queue 2 keeps its place. It continues from that slot once queue 1 is no longer running. Three conditions are reported through sticky per-queue flags, each cleared by software:

- a trigger that arrives while its queue is busy (overrun);
- a queue that has finished its last slot (completion);
- a queue that has stopped at a marked pause slot, shown in its status output.

Top module: `dualq_sched`

## Requirements
- R1: After reset both status outputs read idle (2'b00), all overrun and completion flags are 0, and `cmd_valid` is 0.
- R2: A rising trigger edge is registered one cycle after the edge. In the following cycle the queue status reads active (2'b01). One cycle later `cmd_valid` rises with `cmd_idx` equal to the queue's first slot. Later slots follow in increasing order. Queue 1's window runs from `q1_first` to `q1_last`, and queue 2's runs from `q1_last`+1 to `q2_last`.
- R3: At most one command is outstanding. While `cmd_valid` is high and `cmd_done` is low, `cmd_valid` and `cmd_idx` hold steady. The next slot is issued no earlier than the second cycle after the acknowledge. A `cmd_done` pulse while `cmd_valid` is low has no effect.
- R4: The acknowledge of a queue's last slot sets its completion flag and returns its status to idle in the same cycle.
- R5: A trigger edge registered while its queue is active or paused sets that queue's overrun flag. The queue does not restart, and the trigger is not saved for later. The queue is idle again after its single run.
- R6: After a queue completes, its next trigger edge runs the queue again from its first slot.
- R7: Queue 1 takes priority. A queue 2 slot is issued only when queue 1 status is not active.
- R8: A queue 2 run interrupted by queue 1 resumes at the first slot of queue 2 it had not yet issued, once queue 1 leaves the active state.
- R9: When a slot whose bit is set in `pause_mask` is acknowledged, the queue goes to paused (2'b10) and issues nothing more. This does not apply to the queue's last slot, where completion wins. A pulse on the queue's resume input makes it active again at the next slot. A trigger during the pause only sets overrun.
- R10: Overrun and completion flags stay set until a one-cycle clear pulse. When a set and a clear fall in the same cycle, the flag ends up set.
- R11: A trigger input held high produces only one event. Only a new low-to-high transition counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q1_trig | input | 1 | Queue 1 trigger, rising edge sensitive |
| q2_trig | input | 1 | Queue 2 trigger, rising edge sensitive |
| q1_resume | input | 1 | Continue queue 1 from a pause |
| q2_resume | input | 1 | Continue queue 2 from a pause |
| q1_first | input | 4 | First slot of queue 1 |
| q1_last | input | 4 | Last slot of queue 1 |
| q2_last | input | 4 | Last slot of queue 2 |
| pause_mask | input | 16 | One bit per slot, marking pause points |
| cmd_done | input | 1 | Converter acknowledge of the outstanding slot |
| q1_ovr_clr | input | 1 | Clear queue 1 overrun flag |
| q2_ovr_clr | input | 1 | Clear queue 2 overrun flag |
| q1_cf_clr | input | 1 | Clear queue 1 completion flag |
| q2_cf_clr | input | 1 | Clear queue 2 completion flag |
| cmd_valid | output | 1 | A slot is outstanding at the converter |
| cmd_idx | output | 4 | Index of the outstanding slot |
| q1_status | output | 2 | Queue 1 state: 00 idle, 01 active, 10 paused |
| q2_status | output | 2 | Queue 2 state: 00 idle, 01 active, 10 paused |
| q1_ovr | output | 1 | Queue 1 trigger overrun flag |
| q2_ovr | output | 1 | Queue 2 trigger overrun flag |
| q1_cf | output | 1 | Queue 1 completion flag |
| q2_cf | output | 1 | Queue 2 completion flag |

## Verification
A corrupted queue pointer appears on `cmd_idx` at the very next issue, two cycles after the acknowledge, as a slot out of order or outside its window. A queue state that does not return to idle shows up when the following trigger sets overrun instead of starting a new run. A lost arbitration owner shows up at the next acknowledge: the wrong queue advances, which the ordered index stream exposes within one run. A flag that fails to stick or clear is seen at its own output one cycle after the event.

// File: rtl/dualq_pkg.sv
package dualq_pkg;
   typedef enum logic [1:0] {
      QS_IDLE = 2'b00,
      QS_RUN  = 2'b01,
      QS_HOLD = 2'b10
   } qstate_e;
endpackage

// File: rtl/dualq_edge.sv
// Rising-edge detector with a registered event one cycle after the edge.
module dualq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic ev
);
   logic trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         ev     <= 1'b0;
      end else begin
         trig_q <= trig;
         ev     <= trig & ~trig_q;
      end
   end
endmodule

// File: rtl/dualq_queue.sv
// One queue: state, slot pointer and sticky flags.
module dualq_queue
   import dualq_pkg::*;
#(
   parameter int N_CMD = 16,
   parameter int AW    = $clog2(N_CMD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev,
   input  logic [AW-1:0]    first,
   input  logic [AW-1:0]    last,
   input  logic [N_CMD-1:0] pause_mask,
   input  logic             resume,
   input  logic             step,
   input  logic             ovr_clr,
   input  logic             cf_clr,
   output qstate_e          state,
   output logic [AW-1:0]    ptr,
   output logic             ovr,
   output logic             cf
);
   logic ovr_set;
   logic cf_set;
   logic at_last;

   assign at_last = (ptr == last);
   assign ovr_set = ev && (state != QS_IDLE);
   assign cf_set  = step && (state == QS_RUN) && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= QS_IDLE;
         ptr   <= '0;
      end else begin
         unique case (state)
            QS_IDLE: begin
               if (ev) begin
                  state <= QS_RUN;
                  ptr   <= first;
               end
            end
            QS_RUN: begin
               if (step) begin
                  if (at_last) begin
                     state <= QS_IDLE;
                  end else begin
                     ptr <= ptr + 1'b1;
                     if (pause_mask[ptr]) state <= QS_HOLD;
                  end
               end
            end
            QS_HOLD: begin
               if (resume) state <= QS_RUN;
            end
            default: state <= QS_IDLE;
         endcase
      end
   end

   // Sticky flags: a set in the same cycle as a clear wins.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr <= 1'b0;
         cf  <= 1'b0;
      end else begin
         ovr <= ovr_set | (ovr & ~ovr_clr);
         cf  <= cf_set  | (cf  & ~cf_clr);
      end
   end
endmodule

// File: rtl/dualq_issue.sv
// Fixed-priority issue stage with a single outstanding slot.
module dualq_issue #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run1,
   input  logic          run2,
   input  logic [AW-1:0] ptr1,
   input  logic [AW-1:0] ptr2,
   input  logic          cmd_done,
   output logic          cmd_valid,
   output logic [AW-1:0] cmd_idx,
   output logic          step1,
   output logic          step2,
   output logic          owner
);
   logic busy;
   logic req2;
   logic ack;

   assign req2      = run2 && !run1;
   assign ack       = busy && cmd_done;
   assign step1     = ack && !owner;
   assign step2     = ack &&  owner;
   assign cmd_valid = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         owner   <= 1'b0;
         cmd_idx <= '0;
      end else if (busy) begin
         if (cmd_done) busy <= 1'b0;
      end else if (run1) begin
         busy    <= 1'b1;
         owner   <= 1'b0;
         cmd_idx <= ptr1;
      end else if (req2) begin
         busy    <= 1'b1;
         owner   <= 1'b1;
         cmd_idx <= ptr2;
      end
   end
endmodule

// File: rtl/dualq_sched.sv
module dualq_sched
   import dualq_pkg::*;
#(
   parameter int N_CMD = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       q1_trig,
   input  logic                       q2_trig,
   input  logic                       q1_resume,
   input  logic                       q2_resume,
   input  logic [$clog2(N_CMD)-1:0]   q1_first,
   input  logic [$clog2(N_CMD)-1:0]   q1_last,
   input  logic [$clog2(N_CMD)-1:0]   q2_last,
   input  logic [N_CMD-1:0]           pause_mask,
   input  logic                       cmd_done,
   input  logic                       q1_ovr_clr,
   input  logic                       q2_ovr_clr,
   input  logic                       q1_cf_clr,
   input  logic                       q2_cf_clr,
   output logic                       cmd_valid,
   output logic [$clog2(N_CMD)-1:0]   cmd_idx,
   output logic [1:0]                 q1_status,
   output logic [1:0]                 q2_status,
   output logic                       q1_ovr,
   output logic                       q2_ovr,
   output logic                       q1_cf,
   output logic                       q2_cf
);
   localparam int AW = $clog2(N_CMD);
   localparam int NQ = 2;

   if (N_CMD < 2 || N_CMD > (1 << AW)) begin : g_bad_depth
      $error("dualq_sched: N_CMD must be at least 2");
   end

   logic [NQ-1:0] trig_v, resume_v, ovr_clr_v, cf_clr_v;
   logic [NQ-1:0] q_ev, step_v, ovr_v, cf_v;
   logic [AW-1:0] first_v [NQ];
   logic [AW-1:0] last_v  [NQ];
   logic [AW-1:0] ptr_v   [NQ];
   qstate_e       st_v    [NQ];
   logic          arb_owner;

   assign trig_v    = {q2_trig, q1_trig};
   assign resume_v  = {q2_resume, q1_resume};
   assign ovr_clr_v = {q2_ovr_clr, q1_ovr_clr};
   assign cf_clr_v  = {q2_cf_clr, q1_cf_clr};
   assign first_v[0] = q1_first;
   assign last_v[0]  = q1_last;
   assign first_v[1] = q1_last + 1'b1;
   assign last_v[1]  = q2_last;

   for (genvar gi = 0; gi < NQ; gi++) begin : g_q
      dualq_edge u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .trig  (trig_v[gi]),
         .ev    (q_ev[gi])
      );
      dualq_queue #(.N_CMD(N_CMD), .AW(AW)) u_queue (
         .clk        (clk),
         .rst_n      (rst_n),
         .ev         (q_ev[gi]),
         .first      (first_v[gi]),
         .last       (last_v[gi]),
         .pause_mask (pause_mask),
         .resume     (resume_v[gi]),
         .step       (step_v[gi]),
         .ovr_clr    (ovr_clr_v[gi]),
         .cf_clr     (cf_clr_v[gi]),
         .state      (st_v[gi]),
         .ptr        (ptr_v[gi]),
         .ovr        (ovr_v[gi]),
         .cf         (cf_v[gi])
      );
   end

   dualq_issue #(.AW(AW)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .run1      (st_v[0] == QS_RUN),
      .run2      (st_v[1] == QS_RUN),
      .ptr1      (ptr_v[0]),
      .ptr2      (ptr_v[1]),
      .cmd_done  (cmd_done),
      .cmd_valid (cmd_valid),
      .cmd_idx   (cmd_idx),
      .step1     (step_v[0]),
      .step2     (step_v[1]),
      .owner     (arb_owner)
   );

   assign q1_status = st_v[0];
   assign q2_status = st_v[1];
   assign q1_ovr    = ovr_v[0];
   assign q2_ovr    = ovr_v[1];
   assign q1_cf     = cf_v[0];
   assign q2_cf     = cf_v[1];
endmodule

// File: rtl/dualq_chk.sv
module dualq_chk
   import dualq_pkg::*;
#(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [AW-1:0] cmd_idx,
   input logic          cmd_done,
   input logic [1:0]    q1_status,
   input logic [1:0]    q2_status,
   input logic          q1_ovr,
   input logic          q2_ovr,
   input logic          q1_cf,
   input logic          q1_cf_clr,
   input logic          q1_ovr_clr,
   input logic [1:0]    ev,
   input logic          owner
);
   assert_hold_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_idx)));

   assert_ovr_q1_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[0] && q1_status != QS_IDLE) |=> q1_ovr);

   assert_ovr_q2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[1] && q2_status != QS_IDLE) |=> q2_ovr);

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q1_cf) |-> (q1_status == QS_IDLE));

   assert_q2_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cmd_valid) && owner) |-> ($past(q1_status) != QS_RUN));

   assert_cf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_cf && !q1_cf_clr) |=> q1_cf);

   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_ovr && !q1_ovr_clr) |=> q1_ovr);

   assert_legal_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_status != 2'b11) && (q2_status != 2'b11));
endmodule

bind dualq_sched dualq_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_idx    (cmd_idx),
   .cmd_done   (cmd_done),
   .q1_status  (q1_status),
   .q2_status  (q2_status),
   .q1_ovr     (q1_ovr),
   .q2_ovr     (q2_ovr),
   .q1_cf      (q1_cf),
   .q1_cf_clr  (q1_cf_clr),
   .q1_ovr_clr (q1_ovr_clr),
   .ev         (q_ev),
   .owner      (arb_owner)
);

// File: tb/sim_dualq_sched.sv
module sim_dualq_sched;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic q1_trig = 0, q2_trig = 0, q1_resume = 0, q2_resume = 0;
   logic [3:0] q1_first = 4'd2, q1_last = 4'd5, q2_last = 4'd9;
   logic [15:0] pause_mask = 16'h0;
   logic cmd_done = 0;
   logic q1_ovr_clr = 0, q2_ovr_clr = 0, q1_cf_clr = 0, q2_cf_clr = 0;
   logic cmd_valid;
   logic [3:0] cmd_idx;
   logic [1:0] q1_status, q2_status;
   logic q1_ovr, q2_ovr, q1_cf, q2_cf;

   int n_chk = 0, n_err = 0;
   bit reported = 0;

   always #2 clk = ~clk;

   dualq_sched u0 (.*);

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      end
      $finish;
   endtask

   // which: 0 q1_trig, 1 q2_trig, 2 q1_resume, 3 q1_ovr_clr, 4 q1_cf_clr, 5 q2_cf_clr, 6 q2_ovr_clr
   task automatic pulse(input int which);
      case (which)
         0: q1_trig = 1;  1: q2_trig = 1;  2: q1_resume = 1;
         3: q1_ovr_clr = 1; 4: q1_cf_clr = 1; 5: q2_cf_clr = 1;
         default: q2_ovr_clr = 1;
      endcase
      tick();
      q1_trig = 0; q2_trig = 0; q1_resume = 0;
      q1_ovr_clr = 0; q1_cf_clr = 0; q2_cf_clr = 0; q2_ovr_clr = 0;
   endtask

   task automatic serve_one(input int dly, output int idx);
      int waited = 0;
      while (!cmd_valid && waited < 200) begin
         tick();
         waited++;
      end
      idx = cmd_valid ? int'(cmd_idx) : -1;
      repeat (dly) tick();
      cmd_done = 1;
      tick();
      cmd_done = 0;
   endtask

   task automatic serve_expect(input int exp, input string req);
      int got;
      serve_one(0, got);
      chk(got == exp, req, got, exp);
   endtask

   function automatic int win_len(input int a, input int b);
      return b - a + 1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
   end

   initial begin
      int got;
      int unsigned seed;
      seed = $urandom(1234);
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk(q1_status == 0 && q2_status == 0, "R1 status", q1_status, 0);
      chk({q1_ovr, q2_ovr, q1_cf, q2_cf} == 0, "R1 flags", {q1_ovr, q2_ovr, q1_cf, q2_cf}, 0);
      chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);

      // R2 exact latency
      q1_trig = 1; tick(); q1_trig = 0;
      chk(q1_status == 0, "R2 still idle after edge", q1_status, 0);
      tick();
      chk(q1_status == 1 && !cmd_valid, "R2 active", q1_status, 1);
      tick();
      chk(cmd_valid && cmd_idx == 2, "R2 first slot", cmd_idx, 2);
      // R3 hold while unacknowledged
      repeat (3) tick();
      chk(cmd_valid && cmd_idx == 2, "R3 hold", cmd_idx, 2);
      serve_expect(2, "R2 slot");
      chk(!cmd_valid, "R3 gap after ack", cmd_valid, 0);
      // R5 overrun while active
      pulse(0); tick();
      chk(q1_ovr == 1, "R5 overrun", q1_ovr, 1);
      serve_expect(3, "R5 no restart");
      serve_expect(4, "R2 slot");
      serve_expect(5, "R2 last");
      chk(q1_status == 0 && q1_cf == 1, "R4 complete", {q1_status, q1_cf}, 1);
      repeat (4) tick();
      chk(q1_status == 0 && !cmd_valid, "R5 no queued rerun", q1_status, 0);

      // R10 clears and set-over-clear
      pulse(4);
      chk(q1_cf == 0 && q1_ovr == 1, "R10 cf clear", {q1_cf, q1_ovr}, 1);
      pulse(3);
      chk(q1_ovr == 0, "R10 ovr clear", q1_ovr, 0);
      // R6 rerun from first
      pulse(0);
      serve_expect(2, "R6 restart first");
      q1_trig = 1; tick(); q1_trig = 0; q1_ovr_clr = 1; tick(); q1_ovr_clr = 0;
      chk(q1_ovr == 1, "R10 set beats clear", q1_ovr, 1);
      serve_expect(3, "R6"); serve_expect(4, "R6"); serve_expect(5, "R6");
      pulse(3); pulse(4);

      // R7 / R8 priority and resume of queue 2
      pulse(1);
      serve_expect(6, "R8 q2 first");
      while (!cmd_valid) tick();
      chk(cmd_idx == 7, "R8 q2 second", cmd_idx, 7);
      pulse(0); tick();
      chk(q1_status == 1 && cmd_idx == 7, "R7 q1 waits for ack", cmd_idx, 7);
      cmd_done = 1; tick(); cmd_done = 0;
      serve_expect(2, "R7 q1 preempts");
      chk(q2_status == 1, "R8 q2 still active", q2_status, 1);
      serve_expect(3, "R7"); serve_expect(4, "R7"); serve_expect(5, "R7");
      serve_expect(8, "R8 q2 resumes"); serve_expect(9, "R8 q2 last");
      chk(q1_cf && q2_cf && q2_status == 0, "R4 both done", {q1_cf, q2_cf}, 3);
      pulse(4); pulse(5);

      // R9 pause at slot 3
      pause_mask = 16'h0008;
      pulse(0);
      serve_expect(2, "R9"); serve_expect(3, "R9 pause slot");
      chk(q1_status == 2, "R9 paused", q1_status, 2);
      repeat (3) tick();
      chk(!cmd_valid, "R9 nothing issued", cmd_valid, 0);
      pulse(3);
      pulse(0); tick();
      chk(q1_ovr == 1 && q1_status == 2, "R9 trigger in pause", {q1_ovr, q1_status}, 6);
      pulse(2);
      chk(q1_status == 1, "R9 resumed", q1_status, 1);
      serve_expect(4, "R9 continues"); serve_expect(5, "R9 last");
      chk(q1_cf == 1 && q1_status == 0, "R4 after pause", q1_status, 0);
      pause_mask = 16'h0;
      pulse(3); pulse(4);

      // R11 held trigger
      q1_trig = 1;
      serve_expect(2, "R11"); serve_expect(3, "R11");
      serve_expect(4, "R11"); serve_expect(5, "R11");
      repeat (5) tick();
      chk(q1_status == 0 && q1_ovr == 0 && !cmd_valid, "R11 single event", {q1_status, q1_ovr}, 0);
      q1_trig = 0; tick();
      pulse(4);

      // R3 stray acknowledge ignored
      cmd_done = 1; tick(); cmd_done = 0; tick();
      chk(q1_status == 0 && !cmd_valid, "R3 stray ack", cmd_valid, 0);

      // Random rounds: R2 R7 R8 ordering
      for (int rnd = 0; rnd < 24; rnd++) begin
         int f1, l1, l2, total, n1, n2, gap;
         bit ok;
         f1 = $urandom_range(0, 5);
         l1 = f1 + $urandom_range(0, 3);
         l2 = l1 + 1 + $urandom_range(0, 4);
         q1_first = 4'(f1); q1_last = 4'(l1); q2_last = 4'(l2);
         total = win_len(f1, l1) + win_len(l1 + 1, l2);
         gap = $urandom_range(0, 6);
         n1 = f1; n2 = l1 + 1; ok = 1;
         tick();
         fork
            begin
               pulse(1);
               repeat (gap) tick();
               pulse(0);
            end
            begin
               for (int k = 0; k < total; k++) begin
                  serve_one($urandom_range(0, 3), got);
                  if (got >= f1 && got <= l1) begin
                     if (got != n1) ok = 0;
                     n1++;
                  end else begin
                     if (got != n2 || (n1 != f1 && n1 <= l1)) ok = 0;
                     n2++;
                  end
               end
            end
         join
         chk(ok, "R8 random order", n2, l2 + 1);
         tick();
         chk(q1_cf && q2_cf && q1_status == 0 && q2_status == 0, "R4 random done",
             {q1_cf, q2_cf}, 3);
         pulse(4); pulse(5); pulse(3); pulse(6);
      end
      report();
   end
endmodule